// File: doc/BRIEF.md
# Serial Display RAM Write Decoder

This block turns a stream of bytes from a three-wire serial host link (clock, data, active-low select, MSB first, sampled on the rising clock edge) into write cycles for an on-screen display memory. The memory is organised as 11 rows of 32 columns. The serial pins are oversampled in the system clock domain. Each received byte is then classed as a row address, a column address or a data byte. The class depends on the byte's upper bits and on the packet format that is currently active.

Two single-write formats let a host update scattered cells. A new row may be sent before any column, and the row is kept for later column and data pairs. A third format streams data with automatic address advance, which suits full-screen loads. A column address with its format bit set enters this streaming format. Streaming stays active until the select line goes high again. No device address is used, so a transaction starts with an address byte straight away.

Top module: `osd_ram_wr_decoder`

## Requirements
- R1: After reset, wr_en is low and wr_row, wr_col and wr_data are all zero.
- R2: A byte that arrives where an address is expected and has bit 7 = 1 sets the current row to bits 3..0. Bits 6..4 of that byte are ignored.
- R3: A byte that arrives where an address is expected and has bit 7 = 0 sets the current column to bits 4..0. Bit 5 is ignored. Bit 6 = 1 selects streaming, and bit 6 = 0 selects a single write.
- R4: In single-write mode, the one byte that follows the column address is written to (current row, current column). The decoder then expects an address again, either a new row or just a new column that reuses the kept row.
- R5: In streaming mode, every byte is data, including bytes with bit 7 or bit 6 set. Each data byte is written at the current address, and the column then advances by one.
- R6: When streaming advances past column 31, the column wraps to 0 and the row increments. The row after row 10 is row 0.
- R7: Once streaming has begun, the decoder stays in streaming mode until the select line goes high. The next transaction starts in address mode.
- R8: A high level on the select line discards any partially received byte, and that partial byte never produces a write.
- R9: Each data byte produces exactly one wr_en pulse, one system clock cycle wide.
- R10: The first complete byte after the select line goes low is decoded as an address, with no device address byte before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host, asynchronous to clk |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_mosi | input | 1 | Serial data from the host, MSB first |
| wr_en | output | 1 | One-cycle write strobe to the display RAM |
| wr_row | output | 4 | Row of the write |
| wr_col | output | 5 | Column of the write |
| wr_data | output | 8 | Byte to write |

## Verification
The hardest cases to reach from the pins are the mode-dependent ones: a data byte shaped like a row address, sent while streaming is active, and a select that rises in the middle of a byte. The stimulus deliberately streams bytes with bit 7 and bit 6 set, and it starts streaming at column 22 so the column wrap and the row increment both occur. A separate run starts at row 10, column 31 to reach the row wrap. For the abort case, only four bits are shifted before the select is raised, and the next transaction is a normal one, so any bits left over from the partial byte would shift every later byte and show up as misplaced writes.

// File: rtl/osd_ram_wr_decoder.sv
module osd_ram_wr_decoder #(
  parameter int ROWS = 11,
  parameter int COLS = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     spi_sck,
  input  logic                     spi_cs_n,
  input  logic                     spi_mosi,
  output logic                     wr_en,
  output logic [$clog2(ROWS)-1:0]  wr_row,
  output logic [$clog2(COLS)-1:0]  wr_col,
  output logic [7:0]               wr_data
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

  typedef enum logic [1:0] {S_ADDR, S_DATA, S_STREAM} st_t;

  logic [2:0] sck_q;
  logic [1:0] mosi_q;
  logic [1:0] cs_q;
  logic [6:0] shreg;
  logic [2:0] bit_cnt;
  logic       byte_vld;
  logic [7:0] byte_q;
  st_t        st;
  logic [ROW_W-1:0] row_r;
  logic [COL_W-1:0] col_r;

  wire sel_q  = cs_q[1];
  wire sck_up = sck_q[1] & ~sck_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      mosi_q <= '0;
      cs_q   <= 2'b11;
    end else begin
      sck_q  <= {sck_q[1:0], spi_sck};
      mosi_q <= {mosi_q[0], spi_mosi};
      cs_q   <= {cs_q[0], spi_cs_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      bit_cnt  <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (sel_q) begin
        bit_cnt <= '0;
      end else if (sck_up) begin
        shreg   <= {shreg[5:0], mosi_q[1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld <= 1'b1;
          byte_q   <= {shreg, mosi_q[1]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_ADDR;
      row_r   <= '0;
      col_r   <= '0;
      wr_en   <= 1'b0;
      wr_row  <= '0;
      wr_col  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (sel_q) begin
        st <= S_ADDR;
      end else if (byte_vld) begin
        unique case (st)
          S_ADDR: begin
            if (byte_q[7]) begin
              row_r <= byte_q[ROW_W-1:0];
            end else begin
              col_r <= byte_q[COL_W-1:0];
              st    <= byte_q[6] ? S_STREAM : S_DATA;
            end
          end
          S_DATA: begin
            wr_en   <= 1'b1;
            wr_row  <= row_r;
            wr_col  <= col_r;
            wr_data <= byte_q;
            st      <= S_ADDR;
          end
          S_STREAM: begin
            wr_en   <= 1'b1;
            wr_row  <= row_r;
            wr_col  <= col_r;
            wr_data <= byte_q;
            if (col_r == COL_LAST) begin
              col_r <= '0;
              row_r <= (row_r == ROW_LAST) ? '0 : row_r + 1'b1;
            end else begin
              col_r <= col_r + 1'b1;
            end
          end
          default: st <= S_ADDR;
        endcase
      end
    end
  end
endmodule

module osd_ram_wr_decoder_chk #(
  parameter int ROW_W = 4,
  parameter int COL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_q,
  input logic             byte_vld,
  input logic             byte_is_row,
  input logic [ROW_W-1:0] byte_row,
  input logic             in_addr,
  input logic             in_stream,
  input logic [ROW_W-1:0] row_r,
  input logic [COL_W-1:0] col_r,
  input logic             wr_en,
  input logic [COL_W-1:0] wr_col
);
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R9
  AST_ABORT_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |=> !byte_vld); // R8
  AST_STREAM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stream && !sel_q) |=> in_stream); // R7
  AST_STREAM_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && in_stream && !sel_q) |=> (wr_en && wr_col == $past(col_r))); // R5
  AST_ROW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && in_addr && byte_is_row && !sel_q) |=> (row_r == $past(byte_row))); // R2
  AST_ADDR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && in_addr) |=> !wr_en); // R10
endmodule

bind osd_ram_wr_decoder osd_ram_wr_decoder_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .byte_vld(byte_vld),
  .byte_is_row(byte_q[7]), .byte_row(byte_q[ROW_W-1:0]),
  .in_addr(st == S_ADDR), .in_stream(st == S_STREAM),
  .row_r(row_r), .col_r(col_r), .wr_en(wr_en), .wr_col(wr_col)
);

// File: tb/osd_ram_wr_decoder_bench.sv
module osd_ram_wr_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic       wr_en;
  logic [3:0] wr_row;
  logic [4:0] wr_col;
  logic [7:0] wr_data;
  int total = 0, bad = 0;
  bit done = 0;
  logic [16:0] expq[$];
  logic prev_wr = 1'b0;

  always #10 clk = ~clk;

  osd_ram_wr_decoder u_osd_ram_wr_decoder (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data));

  task automatic push(input int r, input int c, input logic [7:0] d);
    expq.push_back({4'(r), 5'(c), d});
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); mosi = b[i];
      repeat (4) @(negedge clk); sck = 1'b1;
      repeat (4) @(negedge clk); sck = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic sel(input logic lo);
    repeat (6) @(negedge clk); cs_n = ~lo; repeat (6) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        total++;
        if (prev_wr) begin
          bad++; $display("FAIL R9 strobe width: actual=2+ cycles expected=1");
        end
        if (expq.size() == 0) begin
          bad++; $display("FAIL R4/R5 unexpected write: actual=%0d,%0d,%h expected=none", wr_row, wr_col, wr_data);
        end else begin
          logic [16:0] e;
          e = expq.pop_front();
          if ({wr_row, wr_col, wr_data} !== e) begin
            bad++;
            $display("FAIL R2/R3/R4/R5/R6 write: actual=%0d,%0d,%h expected=%0d,%0d,%h",
                     wr_row, wr_col, wr_data, e[16:13], e[12:8], e[7:0]);
          end
        end
      end
      prev_wr = wr_en;
    end
  end

  task automatic drain(input string tag);
    repeat (40) @(negedge clk);
    total++;
    if (expq.size() != 0) begin
      bad++; $display("FAIL %s missing writes: actual=%0d left expected=0", tag, expq.size());
      expq.delete();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (wr_en !== 1'b0 || wr_row !== 0 || wr_col !== 0 || wr_data !== 0) begin
      bad++; $display("FAIL R1 reset: actual=%b %0d %0d %h expected=0 0 0 00", wr_en, wr_row, wr_col, wr_data);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 R4: row, column, data repeated
    push(1, 3, 8'h5A); push(7, 20, 8'hC3);
    sel(1); send(8'h81); send(8'h03); send(8'h5A);
    send(8'h87); send(8'h14); send(8'hC3); sel(0);
    drain("R4 format rcd");

    // R2 R3 R4: ignored bits, then column/data pairs keep the row
    push(3, 5, 8'h11); push(3, 7, 8'h22); push(3, 0, 8'hFF);
    sel(1); send(8'hF3); send(8'h25); send(8'h11);
    send(8'h07); send(8'h22); send(8'h00); send(8'hFF); sel(0);
    drain("R2 R3 ignored bits");

    // R5 R6: stream from row 2 col 22, data with bit 7 set, wraps to row 3
    for (int i = 0; i < 12; i++) push(2 + (22 + i) / 32, (22 + i) % 32, 8'(8'h80 + i));
    sel(1); send(8'h82); send(8'h56);
    for (int i = 0; i < 12; i++) send(8'(8'h80 + i));
    sel(0);
    drain("R5 R6 stream wrap");

    // R6: row after the last row is row 0
    push(10, 31, 8'hAA); push(0, 0, 8'hBB); push(0, 1, 8'h47);
    sel(1); send(8'h8A); send(8'h5F); send(8'hAA); send(8'hBB); send(8'h47); sel(0);
    drain("R6 row wrap");

    // R7: single write, switch to streaming, row/column-like bytes stay data
    push(4, 2, 8'h10); push(4, 1, 8'h90); push(4, 2, 8'h05); push(4, 3, 8'h41);
    sel(1); send(8'h84); send(8'h02); send(8'h10);
    send(8'h41); send(8'h90); send(8'h05); send(8'h41); sel(0);
    drain("R7 stream sticky");

    // R7 R10: after select rises, address mode again
    push(6, 0, 8'h33);
    sel(1); send(8'h86); send(8'h00); send(8'h33); sel(0);
    drain("R7 restart");

    // R8: partial byte aborted by select going high
    sel(1); send_bits(8'hFF, 4); sel(0);
    push(1, 9, 8'h6E);
    sel(1); send(8'h81); send(8'h09); send(8'h6E); sel(0);
    drain("R8 abort");

    // R8: abort in the middle of a stream leaves no write
    push(5, 4, 8'h12);
    sel(1); send(8'h85); send(8'h44); send(8'h12); send_bits(8'h34, 5); sel(0);
    drain("R8 stream abort");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule